// File: doc/BRIEF.md
# Translation Fault Record Bank

This block collects failed translation requests from an address-remapping unit and holds them in a ring of fault records until software has read them. Each report that arrives on the injection port carries a page address, the 16-bit requester identifier, an 8-bit reason code and a read/write type bit. The report is written into the next free record in round-robin order. If that record still holds an unread fault, the report is dropped and a sticky overflow bit is set instead.

Software reaches the bank through a plain 32-bit register port. A status word gives three things: a pending bit that is the OR of every record's valid flag, the overflow bit, and the index of the oldest pending record. Each record exposes its address, identifier and reason/type word, and software frees a record by writing 1 to its valid flag. A control word holds an interrupt mask. A one-cycle fault event pulse is raised when faults become pending while unmasked, or when software unmasks with faults still outstanding.

The byte layout is as follows. Status is the word at 0x00 and control is the word at 0x04. Record i starts at 0x20 + 16*i and has four dwords. Offset +0 holds address bits 31:12 in bits 31:12, with bits 11:0 reading zero. Offset +4 holds address bits 63:32. Offset +8 holds the requester identifier in bits 15:0: bus number in 15:8, device/function in 7:0. Offset +12 holds the valid flag in bit 31, the type in bit 30 (1 = read) and the reason code in bits 7:0. Reason codes 0x20 and up mark interrupt-remapping faults and lower codes mark DMA faults. The bank stores the code as it arrives. Addresses that fall outside this layout read as zero and ignore writes.

Top module: `fault_log_bank`

## Requirements
- R1: After reset the status word reads 0 (nothing pending, no overflow, index 0), the control word reads 0x8000_0000 (mask bit 31 set) and irqOut is low.
- R2: An accepted report is stored with the layout given above. Address bits below bit 12 are discarded, the identifier and reason are kept verbatim, the type goes to bit 30 and the valid flag (bit 31 of +12) becomes 1.
- R3: Accepted reports go to records 0, 1, 2, … in turn. After the last record the next report goes to record 0.
- R4: A report is dropped if the record it targets has its valid flag set, judged on the flags held before that cycle. A dropped report sets overflow (status bit 1) and leaves the record contents and the write position unchanged.
- R5: A write to a record's +12 dword with bit 31 = 1 clears that record's valid flag. A write with bit 31 = 0 has no effect, and writes to the +0, +4 and +8 dwords are ignored.
- R6: A status write with bit 1 = 1 clears overflow. Other status bits are read-only.
- R7: Status bit 0 is 1 exactly when at least one record's valid flag is set.
- R8: Status bits 15:8 give the first record with its flag set, scanning upward from the write position and wrapping to 0. When no record is pending they give the write position.
- R9: When the pending bit rises while the mask is clear, irqOut is high for exactly one cycle: the cycle after the one in which the new flag becomes visible.
- R10: Control bit 31 is the mask and is written directly. While it is set, no pulse is raised. Writing 0 to it while faults are pending raises one pulse in the cycle after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultValid | input | 1 | Fault report strobe, one report per cycle |
| faultAddr | input | ADDR_W | Faulting address (page bits kept) |
| faultSrc | input | 16 | Requester identifier, bus in 15:8, device/function in 7:0 |
| faultReason | input | 8 | Fault reason code |
| faultIsRead | input | 1 | 1 for a read request, 0 for a write |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| irqOut | output | 1 | One-cycle fault event pulse |

## Verification
The bench builds the bank with four records, a 64-bit address and a 12-bit page shift. With four records, a short run of reports is enough to reach the wrap from record 3 to record 0, a completely full ring, and repeated overflow drops. Random frees in the middle of the ring leave holes behind the write position. These holes exercise the wrapped scan for the first pending index. The random mix of mask toggles and frees also produces falling-and-rising pending edges both while masked and while unmasked.

// File: rtl/fault_log_pkg.sv
package fault_log_pkg;
  // widest record index carried in the strobe struct
  localparam int IDX_MAX = 8;
  // word map
  localparam int STATUS_WORD   = 0;
  localparam int CTRL_WORD     = 1;
  localparam int REC_BASE_WORD = 8;
  localparam int REC_WORDS     = 4;
  // bit positions
  localparam int PEND_BIT = 0;
  localparam int OVF_BIT  = 1;
  localparam int MASK_BIT = 31;
  localparam int FLAG_BIT = 31;
  localparam int TYPE_BIT = 30;

  typedef struct packed {
    logic               store;
    logic [IDX_MAX-1:0] storeIdx;
    logic               clear;
    logic [IDX_MAX-1:0] clearIdx;
  } strobe_t;
endpackage

// File: rtl/fault_log_ctrl.sv
module fault_log_ctrl
  import fault_log_pkg::*;
#(
  parameter int NUM_REC = 8,
  parameter int REG_AW  = 8,
  localparam int IDX_W  = (NUM_REC > 1) ? $clog2(NUM_REC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               faultValid,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  input  logic [NUM_REC-1:0] flagVec,
  output strobe_t            stb,
  output logic [IDX_W-1:0]   wrPtr,
  output logic [IDX_W-1:0]   firstIdx,
  output logic               pending,
  output logic               overflow,
  output logic               maskBit,
  output logic               irqOut
);
  logic pendPrev;
  logic maskPrev;
  logic storeOk;
  logic dropHit;
  logic statusWr;
  logic ctrlWr;
  logic recHit;
  int   wordInt;
  int   recRel;
  int   scanIdx;
  logic found;

  assign pending = |flagVec;
  assign storeOk = faultValid && !flagVec[wrPtr];
  assign dropHit = faultValid && flagVec[wrPtr];

  // register write decode
  always_comb begin
    wordInt  = int'(regAddr[REG_AW-1:2]);
    recRel   = wordInt - REC_BASE_WORD;
    recHit   = (wordInt >= REC_BASE_WORD) && (recRel < NUM_REC * REC_WORDS);
    statusWr = regWrEn && (wordInt == STATUS_WORD);
    ctrlWr   = regWrEn && (wordInt == CTRL_WORD);
  end

  always_comb begin
    stb.store    = storeOk;
    stb.storeIdx = IDX_MAX'(wrPtr);
    stb.clear    = regWrEn && recHit && ((recRel & 3) == 3) && regWrData[FLAG_BIT];
    stb.clearIdx = IDX_MAX'(recRel >> 2);
  end

  // circular scan for the oldest pending record
  always_comb begin
    firstIdx = wrPtr;
    found    = 1'b0;
    scanIdx  = 0;
    for (int o = 0; o < NUM_REC; o++) begin
      scanIdx = (int'(wrPtr) + o) % NUM_REC;
      if (!found && flagVec[scanIdx]) begin
        found    = 1'b1;
        firstIdx = IDX_W'(scanIdx);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      overflow <= 1'b0;
      maskBit  <= 1'b1;
      pendPrev <= 1'b0;
      maskPrev <= 1'b1;
      irqOut   <= 1'b0;
    end else begin
      if (storeOk)
        wrPtr <= (wrPtr == IDX_W'(NUM_REC - 1)) ? '0 : wrPtr + 1'b1;
      if (dropHit)
        overflow <= 1'b1;
      else if (statusWr && regWrData[OVF_BIT])
        overflow <= 1'b0;
      if (ctrlWr)
        maskBit <= regWrData[MASK_BIT];
      pendPrev <= pending;
      maskPrev <= maskBit;
      irqOut   <= pending && !maskBit && (!pendPrev || maskPrev);
    end
  end
endmodule

// File: rtl/fault_log_data.sv
module fault_log_data
  import fault_log_pkg::*;
#(
  parameter int NUM_REC    = 8,
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int REG_AW     = 8,
  localparam int IDX_W     = (NUM_REC > 1) ? $clog2(NUM_REC) : 1,
  localparam int PAGE_W    = ADDR_W - PAGE_SHIFT,
  localparam int NUM_WORDS = NUM_REC * REC_WORDS
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [ADDR_W-1:0]  faultAddr,
  input  logic [15:0]        faultSrc,
  input  logic [7:0]         faultReason,
  input  logic               faultIsRead,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [IDX_W-1:0]   firstIdx,
  input  logic               pending,
  input  logic               overflow,
  input  logic               maskBit,
  output logic [NUM_REC-1:0] flagVec,
  output logic [31:0]        regRdData
);
  logic [31:0] recWord [NUM_WORDS];
  int          wordInt;

  for (genvar g = 0; g < NUM_REC; g++) begin : g_rec
    logic [PAGE_W-1:0] page;
    logic [15:0]       src;
    logic [7:0]        reason;
    logic              isRd;
    logic              flag;
    logic [63:0]       fullAddr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        page   <= '0;
        src    <= '0;
        reason <= '0;
        isRd   <= 1'b0;
        flag   <= 1'b0;
      end else if (stb.store && stb.storeIdx == IDX_MAX'(g)) begin
        page   <= faultAddr[ADDR_W-1:PAGE_SHIFT];
        src    <= faultSrc;
        reason <= faultReason;
        isRd   <= faultIsRead;
        flag   <= 1'b1;
      end else if (stb.clear && stb.clearIdx == IDX_MAX'(g)) begin
        flag <= 1'b0;
      end
    end

    assign fullAddr           = 64'(page) << PAGE_SHIFT;
    assign flagVec[g]         = flag;
    assign recWord[g * 4 + 0] = fullAddr[31:0];
    assign recWord[g * 4 + 1] = fullAddr[63:32];
    assign recWord[g * 4 + 2] = {16'b0, src};
    assign recWord[g * 4 + 3] = {flag, isRd, 22'b0, reason};
  end

  always_comb begin
    regRdData = '0;
    wordInt   = int'(regAddr[REG_AW-1:2]);
    if (wordInt == STATUS_WORD)
      regRdData = {16'b0, 8'(firstIdx), 6'b0, overflow, pending};
    else if (wordInt == CTRL_WORD)
      regRdData = {maskBit, 31'b0};
    else if (wordInt >= REC_BASE_WORD && wordInt - REC_BASE_WORD < NUM_WORDS)
      regRdData = recWord[wordInt - REC_BASE_WORD];
  end
endmodule

// File: rtl/fault_log_bank.sv
module fault_log_bank
  import fault_log_pkg::*;
#(
  parameter int NUM_REC    = 8,
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  localparam int REG_AW    = $clog2((REC_BASE_WORD + REC_WORDS * NUM_REC) * 4),
  localparam int IDX_W     = (NUM_REC > 1) ? $clog2(NUM_REC) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic [15:0]       faultSrc,
  input  logic [7:0]        faultReason,
  input  logic              faultIsRead,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqOut
);
  strobe_t            stb;
  logic [NUM_REC-1:0] flagVec;
  logic [IDX_W-1:0]   wrPtr;
  logic [IDX_W-1:0]   firstIdx;
  logic               pending;
  logic               overflow;
  logic               maskBit;

  fault_log_ctrl #(.NUM_REC(NUM_REC), .REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .faultValid(faultValid),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .flagVec(flagVec), .stb(stb), .wrPtr(wrPtr), .firstIdx(firstIdx),
    .pending(pending), .overflow(overflow), .maskBit(maskBit), .irqOut(irqOut)
  );

  fault_log_data #(.NUM_REC(NUM_REC), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
                   .REG_AW(REG_AW)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .faultAddr(faultAddr),
    .faultSrc(faultSrc), .faultReason(faultReason), .faultIsRead(faultIsRead),
    .regAddr(regAddr), .firstIdx(firstIdx), .pending(pending),
    .overflow(overflow), .maskBit(maskBit), .flagVec(flagVec),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/fault_log_chk.sv
module fault_log_chk #(
  parameter int NUM_REC = 8,
  localparam int IDX_W  = (NUM_REC > 1) ? $clog2(NUM_REC) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               faultValid,
  input logic [NUM_REC-1:0] flagVec,
  input logic [IDX_W-1:0]   wrPtr,
  input logic [IDX_W-1:0]   firstIdx,
  input logic               overflow,
  input logic               maskBit,
  input logic               irqOut
);
  function automatic logic [IDX_W-1:0] nextOf(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_REC - 1)) ? '0 : p + 1'b1;
  endfunction

  a_r3_store_advance: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && !flagVec[wrPtr] |=> flagVec[$past(wrPtr)] && wrPtr == nextOf($past(wrPtr)));

  a_r4_drop_overflow: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && flagVec[wrPtr] |=> overflow && $stable(wrPtr));

  a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|flagVec));

  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> !irqOut);

  a_r10_irq_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(!maskBit));

  always_comb begin
    if (rstN) begin
      if (flagVec == '0)
        a_r8_first_idle: assert (firstIdx == wrPtr);
      else
        a_r8_first_flagged: assert (flagVec[firstIdx]);
    end
  end
endmodule

bind fault_log_bank fault_log_chk #(.NUM_REC(NUM_REC)) u_chk (
  .clk(clk), .rstN(rstN), .faultValid(faultValid), .flagVec(flagVec),
  .wrPtr(wrPtr), .firstIdx(firstIdx), .overflow(overflow),
  .maskBit(maskBit), .irqOut(irqOut)
);

// File: tb/fault_log_bank_tb.sv
`timescale 1ns/1ps
module fault_log_bank_tb;
  localparam int N  = 4;
  localparam int AW = $clog2((8 + 4 * N) * 4);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          faultValid = 1'b0;
  logic [63:0]   faultAddr = '0;
  logic [15:0]   faultSrc = '0;
  logic [7:0]    faultReason = '0;
  logic          faultIsRead = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          irqOut;

  fault_log_bank #(.NUM_REC(N), .ADDR_W(64), .PAGE_SHIFT(12)) u_dut (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultAddr(faultAddr),
    .faultSrc(faultSrc), .faultReason(faultReason), .faultIsRead(faultIsRead),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  bit          mFlag [N];
  logic [63:0] mAddr [N];
  logic [15:0] mSrc  [N];
  logic [7:0]  mRsn  [N];
  bit          mRd   [N];
  int          mPtr = 0;
  bit          mOvf = 0;
  bit          mMask = 1;

  function automatic bit mPend();
    for (int i = 0; i < N; i++) if (mFlag[i]) return 1;
    return 0;
  endfunction

  function automatic int mFirst();
    for (int o = 0; o < N; o++) if (mFlag[(mPtr + o) % N]) return (mPtr + o) % N;
    return mPtr;
  endfunction

  function automatic logic [31:0] expStatus();
    return {16'b0, 8'(mFirst()), 6'b0, mOvf, mPend()};
  endfunction

  function automatic logic [31:0] expWord(input int i, input int w);
    case (w)
      0: return {mAddr[i][31:12], 12'b0};
      1: return mAddr[i][63:32];
      2: return {16'b0, mSrc[i]};
      default: return {mFlag[i], mRd[i], 22'b0, mRsn[i]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readChk(input int addr, input logic [31:0] exp, input string req);
    regAddr = AW'(addr);
    #1;
    chk(req, regRdData, exp);
  endtask

  task automatic statusChk(input string req);
    readChk(0, expStatus(), req);
  endtask

  task automatic recordChk(input int i, input string req);
    for (int w = 0; w < 4; w++) readChk(32 + 16 * i + 4 * w, expWord(i, w), req);
  endtask

  // starts and ends just after a falling edge
  task automatic doFault(input logic [63:0] a, input logic [15:0] s,
                         input logic [7:0] r, input bit rd, input string req);
    bit pb, pa;
    pb = mPend();
    faultValid = 1; faultAddr = a; faultSrc = s; faultReason = r; faultIsRead = rd;
    @(posedge clk); @(negedge clk);
    faultValid = 0;
    if (mFlag[mPtr]) mOvf = 1;
    else begin
      mFlag[mPtr] = 1; mAddr[mPtr] = a & ~64'hFFF; mSrc[mPtr] = s;
      mRsn[mPtr] = r; mRd[mPtr] = rd; mPtr = (mPtr + 1) % N;
    end
    pa = mPend();
    @(posedge clk); @(negedge clk);
    chk({req, " irq"}, 32'(irqOut), 32'(!pb && pa && !mMask));
  endtask

  task automatic doWrite(input int addr, input logic [31:0] d, input string req);
    bit mOld;
    mOld = mMask;
    regWrEn = 1; regAddr = AW'(addr); regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 0;
    if (addr == 0 && d[1]) mOvf = 0;
    if (addr == 4) mMask = d[31];
    if (addr >= 32 && addr < 32 + 16 * N && addr % 16 == 12 && d[31])
      mFlag[(addr - 32) / 16] = 0;
    @(posedge clk); @(negedge clk);
    chk({req, " irq"}, 32'(irqOut), 32'(mOld && !mMask && mPend()));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      mFlag[i] = 0; mAddr[i] = '0; mSrc[i] = '0; mRsn[i] = '0; mRd[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 reset state
    statusChk("R1 status");
    readChk(4, 32'h8000_0000, "R1 control");
    chk("R1 irq", 32'(irqOut), 0);

    // R2 layout, R9 unmask then first fault pulses once
    doWrite(4, 32'h0, "R10 unmask idle");
    doFault(64'hDEAD_BEEF_1234_5ABC, 16'h3A15, 8'h05, 1, "R9 first fault");
    recordChk(0, "R2 record0");
    statusChk("R7 pending");
    doFault(64'h0000_0001_FFFF_F123, 16'h0108, 8'h22, 0, "R9 no second pulse");
    doFault(64'h1, 16'hFFFF, 8'h20, 1, "R3 third");
    doFault(64'h8000_0000_0000_0FFF, 16'h00FF, 8'h1F, 0, "R3 fourth");
    recordChk(3, "R2 record3");
    statusChk("R3 wrapped pointer");
    // R4 full ring drops
    doFault(64'h5555_5555_5555_5555, 16'h1234, 8'h11, 1, "R4 drop");
    recordChk(0, "R4 record0 kept");
    statusChk("R4 overflow set");
    // R5 ignored writes
    doWrite(32 + 16 * 1 + 12, 32'h7FFF_FFFF, "R5 bit31 zero");
    doWrite(32 + 16 * 1 + 0, 32'hFFFF_FFFF, "R5 read-only low");
    doWrite(32 + 16 * 1 + 8, 32'hFFFF_FFFF, "R5 read-only src");
    recordChk(1, "R5 record1 intact");
    // R6 overflow clear, bit0 ignored
    doWrite(0, 32'h0000_0001, "R6 bit0 only");
    statusChk("R6 overflow kept");
    doWrite(0, 32'h0000_0002, "R6 clear");
    statusChk("R6 overflow cleared");
    // R8 hole behind pointer: free 1 then 0; write 0
    doWrite(32 + 16 * 1 + 12, 32'h8000_0000, "R5 free1");
    doWrite(32 + 16 * 0 + 12, 32'h8000_0000, "R5 free0");
    statusChk("R8 scan from 0");
    doFault(64'hABCD_0000_0000_7000, 16'h4242, 8'h07, 0, "R3 refill0");
    statusChk("R8 scan skips hole");
    recordChk(1, "R5 record1 freed");
    // R10 masked rise then unmask
    for (int i = 0; i < N; i++) doWrite(32 + 16 * i + 12, 32'h8000_0000, "R7 drain");
    statusChk("R7 drained");
    doWrite(4, 32'h8000_0000, "R10 mask");
    doFault(64'h7000, 16'h0101, 8'h21, 1, "R10 masked fault");
    doWrite(4, 32'h0, "R10 unmask pending");
    doWrite(4, 32'h0, "R10 rewrite zero");
    readChk(4, 32'h0, "R10 control");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k < 4)
        doFault({$urandom, $urandom}, 16'($urandom), 8'($urandom), 1'($urandom), "R3 rand fault");
      else if (k < 7)
        doWrite(32 + 16 * int'($urandom_range(0, N - 1)) + 12, {1'($urandom), 31'($urandom)}, "R5 rand free");
      else if (k < 9)
        doWrite(4, {1'($urandom), 31'h0}, "R10 rand mask");
      else
        doWrite(0, 32'($urandom), "R6 rand status");
      statusChk("R8 rand status");
      if (n % 8 == 0) recordChk(int'($urandom_range(0, N - 1)), "R2 rand record");
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule